// File: doc/BRIEF.md
# Serial Flash Identification Probe and Erase Geometry Selector

This block asks an attached serial flash for its three-byte identification and turns the answer into erase geometry that the rest of the flash subsystem uses. It drives the serial bus itself (SPI mode 0, most significant bit first): it lowers chip select, sends the read-identification opcode, and clocks in the manufacturer byte and the two-byte device code. It then assembles these into a 24-bit identifier.

The identifier is looked up in a table that is fixed by a parameter. Each entry holds an identifier, a sector size in bytes, a sector count and a flag that says whether the device erases uniformly in 4 KiB pieces. The search visits one entry per clock cycle, and the lowest-numbered matching entry is used. A hit yields the total device size, the erase opcode and the erase size. A miss raises an unknown-device indication.

A probe runs once on its own after reset when the auto-probe parameter is set. After that, it runs again whenever the request input is pulsed while the block is idle. Results stay valid and unchanged until the next probe starts.

Top module: `flash_id_probe`

## Requirements
- R1: A probe drives one transfer. Chip select goes low and the opcode 0x9F is sent on the data output, most significant bit first. Exactly 32 serial clock pulses follow, and then chip select returns high. The serial clock is low whenever chip select is high.
- R2: The reported identifier is the three bytes received after the opcode, with the first received byte in bits 23:16 and the last in bits 7:0.
- R3: When the matched entry has its uniform-4K flag set, the erase opcode is 0x20 and the erase size is 4096.
- R4: When the matched entry has its uniform-4K flag clear, the erase opcode is 0xD8 and the erase size equals that entry's sector size.
- R5: On a hit, the device size equals the entry's sector size multiplied by its sector count.
- R6: A table entry whose identifier is 0x000000 never matches, even when the device returns all zeros.
- R7: When no entry matches, unknownDev is 1 and matched is 0. In that case devSize, eraseOpcode and eraseSize are 0, and devId still shows the received identifier.
- R8: When several entries carry the received identifier, the lowest-indexed one supplies the geometry.
- R9: done is high for exactly one cycle per probe. idValid rises together with done and holds, with all result outputs unchanged, until the cycle after the next probe is accepted, when idValid reads 0.
- R10: With AUTO_PROBE set, one probe starts after reset without any request. A probeReq that arrives while busy is 1 is ignored and causes no second transfer.
- R11: During reset, chip select is high, the serial clock is low, and done, idValid and busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probeReq | input | 1 | Start a probe when idle |
| spiMiso | input | 1 | Serial data from flash |
| spiSclk | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to flash |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| idValid | output | 1 | Results valid and held |
| matched | output | 1 | Identifier found in the table |
| unknownDev | output | 1 | Identifier not found |
| devId | output | 24 | Received identifier |
| devSize | output | 32 | Device size in bytes |
| eraseOpcode | output | 8 | Erase opcode to use |
| eraseSize | output | 32 | Bytes removed by one erase |

## Verification
A wrong bit counter or phase register shows up directly on the serial pins. The pulse count per transfer is wrong, or the opcode arrives misaligned, and this is visible when chip select rises, about 66 cycles after the probe starts. A stale or wrongly advanced table index does not show until done. At that point it appears as geometry taken from the wrong entry. The duplicate-identifier entry and the entry at the last index are there so that an early or late stop in the search changes the reported values. A failure to clear or hold the result registers shows up as idValid or geometry changing between probes.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam int ID_W = 24;
  localparam int SIZE_W = 32;
  localparam int CNT_W = 16;
  localparam int OPC_W = 8;
  localparam int ID_BYTES = ID_W / 8;
  localparam int XFER_BITS = OPC_W + 8 * ID_BYTES;

  localparam logic [OPC_W-1:0] OPC_READ_ID = 8'h9F;
  localparam logic [OPC_W-1:0] OPC_ERASE_SMALL = 8'h20;
  localparam logic [OPC_W-1:0] OPC_ERASE_SECT = 8'hD8;
  localparam logic [SIZE_W-1:0] SMALL_ERASE_BYTES = 32'd4096;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [SIZE_W-1:0] sectBytes;
    logic [CNT_W-1:0]  sectCount;
    logic              uniform4k;
  } geomEntryT;

  typedef struct packed {
    logic start;
    logic xferEn;
    logic searchEn;
    logic loadHit;
    logic loadMiss;
  } ctrlStrobeT;

  typedef struct packed {
    logic lastBit;
    logic hit;
    logic lastEntry;
  } dpStatusT;

  function automatic geomEntryT mkEntry(input logic [ID_W-1:0] id,
                                        input logic [SIZE_W-1:0] sectBytes,
                                        input logic [CNT_W-1:0] sectCount,
                                        input logic uniform4k);
    geomEntryT e;
    e.id = id;
    e.sectBytes = sectBytes;
    e.sectCount = sectCount;
    e.uniform4k = uniform4k;
    return e;
  endfunction
endpackage

// File: rtl/flash_id_ctrl.sv
module flash_id_ctrl
  import flash_id_pkg::*;
#(
  parameter bit AUTO_PROBE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       probeReq,
  input  dpStatusT   status,
  output ctrlStrobeT strobe,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_SEARCH, S_FINISH} stateT;

  stateT state, stateNext;
  logic autoPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      autoPending <= AUTO_PROBE;
    end else begin
      state <= stateNext;
      if (strobe.start) autoPending <= 1'b0;
    end
  end

  always_comb begin
    strobe = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (probeReq || autoPending) begin
          strobe.start = 1'b1;
          stateNext = S_XFER;
        end
      end
      S_XFER: begin
        strobe.xferEn = 1'b1;
        if (status.lastBit) stateNext = S_SEARCH;
      end
      S_SEARCH: begin
        strobe.searchEn = 1'b1;
        if (status.hit) begin
          strobe.loadHit = 1'b1;
          stateNext = S_FINISH;
        end else if (status.lastEntry) begin
          strobe.loadMiss = 1'b1;
          stateNext = S_FINISH;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/flash_id_dp.sv
module flash_id_dp
  import flash_id_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter geomEntryT [NUM_ENTRIES-1:0] TABLE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  output dpStatusT          status,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  output logic              done,
  output logic              idValid,
  output logic              matched,
  output logic              unknownDev,
  output logic [ID_W-1:0]   devId,
  output logic [SIZE_W-1:0] devSize,
  output logic [OPC_W-1:0]  eraseOpcode,
  output logic [SIZE_W-1:0] eraseSize
);
  localparam int BIT_CNT_W = $clog2(XFER_BITS);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(XFER_BITS - 1);

  logic                 phase;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [OPC_W-1:0]     txShift;
  logic [ID_W-1:0]      rxShift;
  logic [IDX_W-1:0]     idx;
  geomEntryT            curEntry;
  logic                 idxAdvance;
  logic [SIZE_W+CNT_W-1:0] sizeProd;

  assign curEntry = TABLE[idx];
  assign sizeProd = curEntry.sectBytes * curEntry.sectCount;

  assign status.lastBit = phase && (bitCnt == LAST_BIT);
  assign status.hit = (curEntry.id != '0) && (curEntry.id == rxShift);
  assign idxAdvance = strobe.searchEn && !status.hit && !status.lastEntry;

  generate
    if (NUM_ENTRIES > 1) begin : g_multi
      assign status.lastEntry = (idx == IDX_W'(NUM_ENTRIES - 1));
      always_ff @(posedge clk) begin
        if (!rstN || strobe.start) idx <= '0;
        else if (idxAdvance) idx <= idx + 1'b1;
      end
    end else begin : g_single
      assign status.lastEntry = 1'b1;
      always_ff @(posedge clk) idx <= '0;
    end
  endgenerate

  // Serial shifter: phase 0 holds the clock low, phase 1 high; sampling on the falling step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0;
      bitCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
      spiCsN <= 1'b1;
    end else if (strobe.start) begin
      phase <= 1'b0;
      bitCnt <= '0;
      txShift <= OPC_READ_ID;
      rxShift <= '0;
      spiCsN <= 1'b0;
    end else if (strobe.xferEn) begin
      phase <= ~phase;
      if (phase) begin
        rxShift <= {rxShift[ID_W-2:0], spiMiso};
        txShift <= {txShift[OPC_W-2:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) spiCsN <= 1'b1;
      end
    end
  end

  assign spiSclk = phase;
  assign spiMosi = txShift[OPC_W-1];

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      idValid <= 1'b0;
      matched <= 1'b0;
      unknownDev <= 1'b0;
      devId <= '0;
      devSize <= '0;
      eraseOpcode <= '0;
      eraseSize <= '0;
    end else begin
      done <= strobe.loadHit || strobe.loadMiss;
      if (strobe.start) begin
        idValid <= 1'b0;
        matched <= 1'b0;
        unknownDev <= 1'b0;
        devId <= '0;
        devSize <= '0;
        eraseOpcode <= '0;
        eraseSize <= '0;
      end else if (strobe.loadHit) begin
        idValid <= 1'b1;
        matched <= 1'b1;
        devId <= rxShift;
        devSize <= sizeProd[SIZE_W-1:0];
        if (curEntry.uniform4k) begin
          eraseOpcode <= OPC_ERASE_SMALL;
          eraseSize <= SMALL_ERASE_BYTES;
        end else begin
          eraseOpcode <= OPC_ERASE_SECT;
          eraseSize <= curEntry.sectBytes;
        end
      end else if (strobe.loadMiss) begin
        idValid <= 1'b1;
        unknownDev <= 1'b1;
        devId <= rxShift;
      end
    end
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter bit AUTO_PROBE = 1'b1,
  parameter geomEntryT [NUM_ENTRIES-1:0] TABLE = {
    mkEntry(24'h202018, 32'd262144, 16'd64, 1'b0),
    mkEntry(24'h202016, 32'd65536, 16'd64, 1'b0),
    mkEntry(24'hEF3013, 32'd65536, 16'd8, 1'b1),
    mkEntry(24'h000000, 32'd65536, 16'd16, 1'b0)
  }
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        probeReq,
  input  logic        spiMiso,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  output logic        busy,
  output logic        done,
  output logic        idValid,
  output logic        matched,
  output logic        unknownDev,
  output logic [23:0] devId,
  output logic [31:0] devSize,
  output logic [7:0]  eraseOpcode,
  output logic [31:0] eraseSize
);
  ctrlStrobeT strobe;
  dpStatusT   status;

  flash_id_ctrl #(.AUTO_PROBE(AUTO_PROBE)) u_ctrl (
    .clk(clk), .rstN(rstN), .probeReq(probeReq),
    .status(status), .strobe(strobe), .busy(busy)
  );

  flash_id_dp #(.NUM_ENTRIES(NUM_ENTRIES), .TABLE(TABLE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .spiMiso(spiMiso), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .done(done), .idValid(idValid), .matched(matched), .unknownDev(unknownDev),
    .devId(devId), .devSize(devSize), .eraseOpcode(eraseOpcode), .eraseSize(eraseSize)
  );
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk (
  input logic        clk,
  input logic        rstN,
  input logic        spiSclk,
  input logic        spiCsN,
  input logic        busy,
  input logic        done,
  input logic        idValid,
  input logic        matched,
  input logic        unknownDev,
  input logic [23:0] devId,
  input logic [31:0] devSize,
  input logic [7:0]  eraseOpcode,
  input logic [31:0] eraseSize
);
  logic [7:0] pulseCnt;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= spiSclk;
      if (spiCsN) pulseCnt <= '0;
      else if (spiSclk && !sclkPrev) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk); // R1
  AST_XFER_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> (pulseCnt == 8'd32)); // R1
  AST_SMALL_ERASE_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (matched && eraseOpcode == 8'h20) |-> (eraseSize == 32'd4096)); // R3
  AST_ERASE_OPC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    matched |-> (eraseOpcode == 8'h20 || eraseOpcode == 8'hD8)); // R4
  AST_ZERO_ID_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    matched |-> (devId != 24'h0)); // R6
  AST_MISS_GEOM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unknownDev |-> (!matched && devSize == 32'h0 && eraseSize == 32'h0)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (idValid && busy)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && $past(idValid)) |-> ($stable(devId) && $stable(devSize) && $stable(eraseOpcode))); // R9
endmodule

bind flash_id_probe flash_id_probe_chk u_chk (.*);

// File: tb/flash_id_probe_test.sv
`timescale 1ns/1ps
module flash_id_probe_test;
  import flash_id_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic probeReq = 1'b0;
  logic spiMiso = 1'b0;
  logic spiSclk, spiCsN, spiMosi, busy, done, idValid, matched, unknownDev;
  logic [23:0] devId;
  logic [31:0] devSize, eraseSize;
  logic [7:0] eraseOpcode;

  always #5 clk = ~clk;

  flash_id_probe #(
    .NUM_ENTRIES(5),
    .AUTO_PROBE(1'b1),
    .TABLE({
      mkEntry(24'hC22017, 32'd65536, 16'd128, 1'b1),
      mkEntry(24'hEF3013, 32'd262144, 16'd2, 1'b0),
      mkEntry(24'h202016, 32'd65536, 16'd64, 1'b0),
      mkEntry(24'hEF3013, 32'd65536, 16'd8, 1'b1),
      mkEntry(24'h000000, 32'd65536, 16'd16, 1'b0)
    })
  ) uut (.*);

  // Flash model
  logic [23:0] modelId = 24'hEF3013;
  logic [31:0] resp;
  logic [7:0] cmdRx;
  int pulseCnt = 0;
  int bitIdx = 0;
  assign resp = {8'h00, modelId};

  always @(negedge spiCsN) begin
    bitIdx = 0;
    pulseCnt = 0;
    cmdRx = 8'h00;
    spiMiso = resp[31];
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    if (pulseCnt < 8) cmdRx = {cmdRx[6:0], spiMosi};
    pulseCnt++;
    bitIdx++;
  end
  always @(negedge spiSclk) if (!spiCsN && bitIdx < 32) spiMiso = resp[31 - bitIdx];

  int compared = 0;
  int mismatched = 0;
  int doneCnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [23:0] id;
    logic        hit;
    logic [31:0] size;
    logic [7:0]  opc;
    logic [31:0] esz;
    string       req;
  } expT;
  expT expQ[$];

  // Monitor: pop expected items on done
  always @(negedge clk) begin
    if (rstN && done) begin
      doneCnt++;
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(cmdRx == 8'h9F, "R1", "opcode", {24'h0, cmdRx}, 32'h9F);
        chk(pulseCnt == 32, "R1", "pulse count", pulseCnt, 32);
        chk(devId == e.id, "R2", "devId", {8'h0, devId}, {8'h0, e.id});
        chk(matched == e.hit, e.req, "matched", {31'h0, matched}, {31'h0, e.hit});
        chk(unknownDev == !e.hit, "R7", "unknownDev", {31'h0, unknownDev}, {31'h0, !e.hit});
        chk(devSize == e.size, "R5", "devSize", devSize, e.size);
        chk(eraseOpcode == e.opc, e.req, "eraseOpcode", {24'h0, eraseOpcode}, {24'h0, e.opc});
        chk(eraseSize == e.esz, e.req, "eraseSize", eraseSize, e.esz);
        chk(idValid == 1'b1, "R9", "idValid with done", {31'h0, idValid}, 32'd1);
      end
    end
  end

  task automatic pushExp(input logic [23:0] id, input logic hit, input logic [31:0] size,
                         input logic [7:0] opc, input logic [31:0] esz, input string req);
    expT e;
    e.id = id; e.hit = hit; e.size = size; e.opc = opc; e.esz = esz; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic waitDone(input int target);
    while (doneCnt < target) @(negedge clk);
  endtask

  task automatic checkHold(input string req);
    logic [31:0] s0;
    logic [7:0] o0;
    @(negedge clk);
    chk(done == 1'b0, req, "done width", {31'h0, done}, 32'd0);
    s0 = devSize; o0 = eraseOpcode;
    repeat (20) @(negedge clk);
    chk(idValid == 1'b1 && devSize == s0 && eraseOpcode == o0, req, "hold",
        {31'h0, idValid}, 32'd1);
  endtask

  task automatic runProbe(input logic [23:0] id, input logic hit, input logic [31:0] size,
                          input logic [7:0] opc, input logic [31:0] esz, input string req);
    int target;
    target = doneCnt + 1;
    modelId = id;
    pushExp(id, hit, size, opc, esz, req);
    @(negedge clk);
    probeReq = 1'b1;
    @(negedge clk);
    probeReq = 1'b0;
    chk(idValid == 1'b0, "R9", "idValid cleared at start", {31'h0, idValid}, 32'd0);
    waitDone(target);
    checkHold("R9");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(spiCsN == 1'b1 && spiSclk == 1'b0, "R11", "bus idle in reset", {30'h0, spiCsN, spiSclk}, 32'h2);
    chk(done == 1'b0 && idValid == 1'b0 && busy == 1'b0, "R11", "flags in reset",
        {29'h0, done, idValid, busy}, 32'h0);

    // R10 auto probe, R3/R8 duplicate id, first entry wins
    pushExp(24'hEF3013, 1'b1, 32'd524288, 8'h20, 32'd4096, "R3 R8");
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R10", "auto probe busy", {31'h0, busy}, 32'd1);
    waitDone(1);
    checkHold("R9");

    // R4 plain sector erase
    runProbe(24'h202016, 1'b1, 32'd4194304, 8'hD8, 32'd65536, "R4");
    // R3 last table entry, 4K flag
    runProbe(24'hC22017, 1'b1, 32'd8388608, 8'h20, 32'd4096, "R3");
    // R6 all-zero id never matches
    runProbe(24'h000000, 1'b0, 32'd0, 8'h00, 32'd0, "R6");
    // R7 unknown id
    runProbe(24'h123456, 1'b0, 32'd0, 8'h00, 32'd0, "R7");

    // R10 request while busy is ignored
    base = doneCnt;
    modelId = 24'h202016;
    pushExp(24'h202016, 1'b1, 32'd4194304, 8'hD8, 32'd65536, "R4");
    @(negedge clk); probeReq = 1'b1;
    @(negedge clk); probeReq = 1'b0;
    repeat (10) @(negedge clk);
    probeReq = 1'b1;
    @(negedge clk); probeReq = 1'b0;
    waitDone(base + 1);
    repeat (100) @(negedge clk);
    chk(doneCnt == base + 1, "R10", "single done", doneCnt, base + 1);
    chk(busy == 1'b0 && spiCsN == 1'b1, "R10", "no second transfer", {30'h0, busy, spiCsN}, 32'h1);
    chk(expQ.size() == 0, "R10", "scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule